// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address stream of a four-beat burst for a pipelined synchronous memory. A load strobe captures a full start address, and each advance strobe then steps the burst by one beat. Only the lowest two address bits move; every higher bit keeps the value captured at the load. A mode input picks the beat order. In linear order the low bits count upward and wrap modulo four. In interleaved order the low bits are the start bits XORed with the beat number.

The generator keeps the captured address and a two-bit beat counter in registers. The output address is formed from these registers and the mode input. A stall input freezes both registers, so the sequence resumes where it stopped once the stall is released. The mode input is expected to stay static during operation.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the captured address and the beat counter both become zero, so `addr` reads 0 after the edge.
- R2: At an edge with `stall` low and `load` high, `start_addr` is captured and the beat counter clears. From the next cycle `addr` equals the captured start address in both orders.
- R3: With `interleave` low (linear order), `addr[1:0]` after k advances equals (start[1:0] + k) mod 4. For example, a start of 01 gives 01, 10, 11, 00.
- R4: With `interleave` high (interleaved order), `addr[1:0]` after k advances equals start[1:0] XOR (k mod 4). For example, a start of 01 gives 01, 00, 11, 10.
- R5: An edge with `stall` low, `load` low and `advance` high steps the burst by one beat. After the fourth advance, `addr` is back at the start address.
- R6: Advances never change `addr[ADDR_W-1:2]`; those bits always equal the upper bits of the last captured start address.
- R7: At an edge with `stall` high, `load` and `advance` are ignored and `addr` keeps its value.
- R8: When `load` and `advance` are both high with `stall` low, the load wins: the new start address appears at beat zero.
- R9: An edge with `stall`, `load` and `advance` all low leaves `addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | High freezes the generator state |
| load | input | 1 | Captures `start_addr` and begins a burst |
| advance | input | 1 | Steps the burst by one beat |
| start_addr | input | ADDR_W | Burst start address |
| interleave | input | 1 | 0 = linear order, 1 = interleaved order |
| addr | output | ADDR_W | Current burst address |

## Verification
Every one of the four low-bit start values is run through a full burst in both orders. Starts 00 and 10 give the same sequence in both modes, while starts 01 and 11 do not, so only those two starts can show whether the wrong order is being produced. Long advance runs past the fourth beat check the wraparound. Start addresses with mixed upper bits would expose any carry leaking out of the low two bits. Stall cycles placed mid-burst with load or advance held high, simultaneous load and advance, and idle gaps separate freezing, load priority and plain holding.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } cmd_e;

    // Stall dominates, then load, then advance.
    function automatic cmd_e decode_cmd(input logic stall, input logic load, input logic advance);
        if (stall)   return CMD_HOLD;
        if (load)    return CMD_LOAD;
        if (advance) return CMD_STEP;
        return CMD_HOLD;
    endfunction

endpackage

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    output logic [BEAT_W-1:0] beat
);

    localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            case (cmd)
                CMD_LOAD: beat <= '0;
                CMD_STEP: beat <= beat + ONE;
                default:  beat <= beat;
            endcase
        end
    end

    assert_clear_on_load_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (beat == '0));

    assert_step_wraps_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP) |=> (beat == $past(beat) + ONE));

    assert_counter_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_HOLD) |=> $stable(beat));

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] base
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
        end else if (cmd == CMD_LOAD) begin
            base <= start_addr;
        end
    end

    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (base == $past(start_addr)));

    assert_base_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_LOAD) |=> $stable(base));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  order_e            order,
    input  logic [BEAT_W-1:0] start_low,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] low
);

    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    // Linear: modular sum, wraps naturally in BEAT_W bits.
    assign lin_low = start_low + beat;

    // Interleaved: bitwise toggling of the start bits by the beat number.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_low[b] = start_low[b] ^ beat[b];
    end

    always_comb begin
        case (order)
            ORDER_INTERLEAVED: low = ilv_low;
            default:           low = lin_low;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              interleave,
    output logic [ADDR_W-1:0] addr
);

    localparam int HI_W = ADDR_W - BEAT_W;

    cmd_e              cmd;
    order_e            order;
    logic [ADDR_W-1:0] base;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low;

    assign cmd   = decode_cmd(stall, load, advance);
    assign order = order_e'(interleave);

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .start_addr (start_addr),
        .base       (base)
    );

    burst_beat_counter #(.BEAT_W(BEAT_W)) u_beat (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .beat (beat)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .order     (order),
        .start_low (base[BEAT_W-1:0]),
        .beat      (beat),
        .low       (low)
    );

    assign addr = {base[ADDR_W-1:BEAT_W], low};

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (addr == '0));

    assert_load_visible_R2: assert property (@(posedge clk) disable iff (rst)
        (!stall && load) |=> (addr == $past(start_addr)));

    assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (rst)
        (!stall && !load) |=> (addr[ADDR_W-1:BEAT_W] == $past(addr[ADDR_W-1:BEAT_W])));

    assert_stall_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (stall && $stable(interleave)) |=> ((addr == $past(addr)) || (interleave != $past(interleave))));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!stall && !load && !advance) |=> ((addr == $past(addr)) || (interleave != $past(interleave))));

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              stall = 1'b0;
    logic              load = 1'b0;
    logic              advance = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              interleave = 1'b0;
    logic [ADDR_W-1:0] addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    int ref_base = 0;
    int ref_cnt  = 0;

    burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(2)) i_burst_addr_gen (
        .clk        (clk),
        .rst        (rst),
        .stall      (stall),
        .load       (load),
        .advance    (advance),
        .start_addr (start_addr),
        .interleave (interleave),
        .addr       (addr)
    );

    always #10 clk = ~clk;

    function automatic int expected_addr();
        int lo;
        int s;
        s = ref_base & 3;
        if (interleave) lo = s ^ ref_cnt;
        else            lo = (s + ref_cnt) % 4;
        return (ref_base & ~3) | lo;
    endfunction

    task automatic check(input string tag);
        int exp_v;
        exp_v = expected_addr();
        checks++;
        if (int'(addr) != exp_v) begin
            errors++;
            $display("FAIL %s: addr=%05h expected=%05h", tag, addr, exp_v[ADDR_W-1:0]);
        end
    endtask

    // Drive at negedge, model at posedge, compare at next negedge.
    task automatic cycle(input logic r, input logic st, input logic ld, input logic adv,
                         input int sa, input logic md, input string tag);
        rst = r; stall = st; load = ld; advance = adv;
        start_addr = sa[ADDR_W-1:0]; interleave = md;
        @(posedge clk);
        if (r) begin
            ref_base = 0; ref_cnt = 0;
        end else if (!st) begin
            if (ld) begin
                ref_base = sa & ((1 << ADDR_W) - 1); ref_cnt = 0;
            end else if (adv) begin
                ref_cnt = (ref_cnt + 1) % 4;
            end
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic burst(input int sa, input logic md, input string tag);
        cycle(0, 0, 1, 0, sa, md, "R2 load");
        for (int k = 0; k < 5; k++) begin
            cycle(0, 0, 0, 1, 32'h0, md, tag);
            checks++;
            if (addr[ADDR_W-1:2] != sa[ADDR_W-1:2]) begin
                errors++;
                $display("FAIL R6: upper=%05h expected=%05h", addr[ADDR_W-1:2], sa[ADDR_W-1:2]);
            end
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cycle(1, 0, 1, 1, 32'hFFFFF, 0, "R1 reset");
        cycle(1, 1, 0, 0, 32'h12345, 1, "R1 reset");
        cycle(0, 0, 0, 0, 32'h0, 0, "R9 idle");

        // Linear bursts for all starts (R3, wrap R5)
        for (int s = 0; s < 4; s++) burst(32'hABCD0 | s, 0, "R3 linear");
        // Interleaved bursts for all starts (R4, wrap R5)
        for (int s = 0; s < 4; s++) burst(32'h5A5A4 | s, 1, "R4 interleaved");
        // Carry must not leak into upper bits
        burst(32'h0FFFF, 0, "R6 carry");
        burst(32'hFFFFF, 1, "R5 wrap");

        // Stall mid-burst with load and advance active
        cycle(0, 0, 1, 0, 32'h33331, 0, "R2 load");
        cycle(0, 0, 0, 1, 32'h0, 0, "R3 step");
        cycle(0, 1, 1, 1, 32'h77777, 0, "R7 stall");
        cycle(0, 1, 0, 1, 32'h0, 0, "R7 stall");
        cycle(0, 1, 1, 0, 32'h11112, 0, "R7 stall");
        cycle(0, 0, 0, 1, 32'h0, 0, "R5 resume");

        // Load wins over advance
        cycle(0, 0, 1, 1, 32'h44443, 1, "R8 priority");
        cycle(0, 0, 1, 1, 32'h22221, 1, "R8 priority");
        cycle(0, 0, 0, 1, 32'h0, 1, "R4 step");

        // Idle holds
        cycle(0, 0, 0, 0, 32'h99999, 1, "R9 idle");
        cycle(0, 0, 0, 0, 32'h0, 1, "R9 idle");
        cycle(0, 0, 0, 1, 32'h0, 1, "R5 step");
        cycle(0, 0, 0, 0, 32'h0, 1, "R9 idle");

        // Reset mid-burst
        cycle(1, 1, 0, 1, 32'h0, 0, "R1 reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule